// File: doc/BRIEF.md
# Audio Serial Port Master Clock Generator

This block produces the bit clock and the frame clock of an audio serial port that runs as clock master. Both are divided down from the fast master clock that the block itself runs on. A single packed control word selects the framing style and carries two divisors. The bit-clock divisor gives the number of master clocks in one bit clock. The frame divisor gives the number of bit clocks in one frame.

In two-channel framing the frame clock is a word-select level that changes at each half frame. In multi-slot (TDM) framing it is a sync pulse one bit clock wide at the start of every frame. The frame length grows with the channel count while the bit-clock divisor shrinks by the same factor, so the frame rate does not change. For example, 16-bit stereo uses 32 bit clocks per frame and 32-bit stereo uses 64.

Two one-cycle strobes tell the serializers where each bit clock falls and where each frame begins. A parameter selects one of two bit layouts for the divisor fields.

Top module: `audio_clkgen`

## Requirements
- R1: While the active configuration has its enable bit (control bit 0) low, `bclk_o`, `fclk_o`, `bfall_o` and `fstart_o` are all low. After reset the block is disabled.
- R2: Control bit 1 selects the framing: 0 gives word-select framing and 1 gives TDM sync framing.
- R3: With `ALT_LAYOUT=0`, the frame divisor F is control bits 10:2 and the bit-clock divisor B is control bits 23:11.
- R4: With `ALT_LAYOUT=1`, F is control bits 12:2 and B is control bits 23:13.
- R5: While enabled, `bclk_o` repeats every B master cycles. It is high for the first ceil(B/2) cycles of each bit period and low for the rest, so an odd B puts the extra cycle in the high phase.
- R6: A frame lasts F bit periods (F*B master cycles). `fstart_o` is high only in the first master cycle of each frame, and `bclk_o` is high in that cycle.
- R7: In word-select framing, `fclk_o` is low during bit periods 0 to floor(F/2)-1 of each frame and high during the remaining bit periods.
- R8: In TDM framing, `fclk_o` is high during bit period 0 of each frame only.
- R9: A divisor field of zero acts as one. With B equal to one, `bclk_o` stays high and `bfall_o` is high on every master cycle.
- R10: With B of two or more, `bfall_o` is high exactly in the first low cycle of every bit period.
- R11: While enabled, a new control word takes effect only at the end of a frame. This includes clearing the enable bit.
- R12: While disabled, a control word with the enable bit set takes effect at once: the master cycle after it is sampled is the first cycle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | CTRL_W (24) | Packed control word: enable, framing select, two divisors |
| bclk_o | output | 1 | Serial bit clock |
| fclk_o | output | 1 | Word-select level or TDM frame sync |
| bfall_o | output | 1 | One-cycle strobe in the first low cycle of each bit period |
| fstart_o | output | 1 | One-cycle strobe in the first cycle of each frame |

## Verification
The assertions take for granted that reset is applied before the first enable. They also assume every divisor value fits its field, since the control word has no bits beyond the two fields to hold anything larger. The falling-edge assertion holds only for B of two or more, because with B equal to one no edge exists. The bench builds every control word through layout-specific packing functions that mask each divisor to its field width. It may change the word in any cycle, including mid-frame, which relies only on the frame-boundary rule and never on a hold time of the input.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;
    // widest divisor fields over both layouts
    localparam int FDIV_W = 11;
    localparam int BDIV_W = 13;

    typedef struct packed {
        logic              en;
        logic              tdm;
        logic [FDIV_W-1:0] fdiv;   // bit clocks per frame, never zero
        logic [BDIV_W-1:0] bdiv;   // master clocks per bit clock, never zero
    } clk_cfg_t;
endpackage

// File: rtl/acg_ctrl_decode.sv
module acg_ctrl_decode
    import audio_clkgen_pkg::*;
#(
    parameter int CTRL_W     = 24,
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output clk_cfg_t          cfg_o
);
    localparam int F_LO = 2;
    localparam int F_HI = ALT_LAYOUT ? 12 : 10;
    localparam int B_LO = F_HI + 1;
    localparam int B_HI = CTRL_W - 1;
    localparam int F_W  = F_HI - F_LO + 1;
    localparam int B_W  = B_HI - B_LO + 1;

    logic [F_W-1:0] f_raw;
    logic [B_W-1:0] b_raw;

    generate
        if (ALT_LAYOUT) begin : g_alt
            assign f_raw = ctrl_i[12:2];
            assign b_raw = ctrl_i[B_HI:13];
        end else begin : g_def
            assign f_raw = ctrl_i[10:2];
            assign b_raw = ctrl_i[B_HI:11];
        end
    endgenerate

    // R9: zero divisor fields act as one
    always_comb begin
        cfg_o.en   = ctrl_i[0];
        cfg_o.tdm  = ctrl_i[1];
        cfg_o.fdiv = (f_raw == '0) ? FDIV_W'(1) : FDIV_W'(f_raw);
        cfg_o.bdiv = (b_raw == '0) ? BDIV_W'(1) : BDIV_W'(b_raw);
    end
endmodule

// File: rtl/acg_timing.sv
module acg_timing
    import audio_clkgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  clk_cfg_t cfg_i,
    output logic     bclk_o,
    output logic     fclk_o,
    output logic     bfall_o,
    output logic     fstart_o
);
    typedef struct packed {
        clk_cfg_t          cfg;
        logic [BDIV_W-1:0] mcnt;    // master cycle within bit period
        logic [FDIV_W-1:0] bcnt;    // bit period within frame
        logic              bclk;
        logic              fclk;
        logic              bfall;
        logic              fstart;
    } tstate_t;

    tstate_t           st_d, st_q;
    logic              last_bit, last_frame;
    logic [BDIV_W:0]   hi_len;
    logic [FDIV_W-1:0] half_f;

    always_comb begin
        st_d       = st_q;
        last_bit   = (st_q.mcnt == st_q.cfg.bdiv - BDIV_W'(1));
        last_frame = last_bit && (st_q.bcnt == st_q.cfg.fdiv - FDIV_W'(1));

        // R11 / R12: reload at frame end, or freely while disabled
        if (!st_q.cfg.en || last_frame) begin
            st_d.cfg  = cfg_i;
            st_d.mcnt = '0;
            st_d.bcnt = '0;
        end else if (last_bit) begin
            st_d.mcnt = '0;
            st_d.bcnt = st_q.bcnt + FDIV_W'(1);
        end else begin
            st_d.mcnt = st_q.mcnt + BDIV_W'(1);
        end

        hi_len = ({1'b0, st_d.cfg.bdiv} + (BDIV_W+1)'(1)) >> 1;
        half_f = st_d.cfg.fdiv >> 1;

        st_d.bclk   = st_d.cfg.en && ({1'b0, st_d.mcnt} < hi_len);
        st_d.bfall  = st_d.cfg.en && ((st_d.cfg.bdiv == BDIV_W'(1)) ||
                                      ({1'b0, st_d.mcnt} == hi_len));
        st_d.fstart = st_d.cfg.en && (st_d.mcnt == '0) && (st_d.bcnt == '0);
        st_d.fclk   = st_d.cfg.en && (st_d.cfg.tdm ? (st_d.bcnt == '0)
                                                   : (st_d.bcnt >= half_f));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bclk_o   = st_q.bclk;
    assign fclk_o   = st_q.fclk;
    assign bfall_o  = st_q.bfall;
    assign fstart_o = st_q.fstart;

    // R1
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.en |-> (!bclk_o && !fclk_o && !bfall_o && !fstart_o));
    // R5
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.en |-> (st_q.mcnt < st_q.cfg.bdiv && st_q.bcnt < st_q.cfg.fdiv));
    // R6
    a_r6_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        fstart_o |-> bclk_o);
    // R10
    a_r10_fall_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.en && st_q.cfg.bdiv > BDIV_W'(1) && $fell(bclk_o)) |-> bfall_o);
    // R8
    a_r8_sync_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        (fstart_o && st_q.cfg.tdm) |-> fclk_o);
    // R7
    a_r7_ws_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (fstart_o && !st_q.cfg.tdm && st_q.cfg.fdiv > FDIV_W'(1)) |-> !fclk_o);
    // R11
    a_r11_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.en && !last_frame) |=> $stable(st_q.cfg));
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int CTRL_W     = 24,
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              bclk_o,
    output logic              fclk_o,
    output logic              bfall_o,
    output logic              fstart_o
);
    clk_cfg_t cfg_dec;

    acg_ctrl_decode #(.CTRL_W(CTRL_W), .ALT_LAYOUT(ALT_LAYOUT)) u_dec (
        .ctrl_i (ctrl_i),
        .cfg_o  (cfg_dec)
    );

    acg_timing u_tim (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg_dec),
        .bclk_o   (bclk_o),
        .fclk_o   (fclk_o),
        .bfall_o  (bfall_o),
        .fstart_o (fstart_o)
    );
endmodule

// File: tb/audio_clkgen_tb.sv
`timescale 1ns/1ps
module audio_clkgen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] ctrl_d = '0, ctrl_a = '0;
    logic bclk_d, fclk_d, bfall_d, fst_d;
    logic bclk_a, fclk_a, bfall_a, fst_a;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    audio_clkgen #(.ALT_LAYOUT(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_d),
        .bclk_o(bclk_d), .fclk_o(fclk_d), .bfall_o(bfall_d), .fstart_o(fst_d));

    audio_clkgen #(.ALT_LAYOUT(1'b1)) u_alt (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_a),
        .bclk_o(bclk_a), .fclk_o(fclk_a), .bfall_o(bfall_a), .fstart_o(fst_a));

    function automatic logic [23:0] mk_def(bit en, bit tdm, int f, int b);
        return {b[12:0], f[8:0], tdm, en};
    endfunction

    function automatic logic [23:0] mk_alt(bit en, bit tdm, int f, int b);
        return {b[10:0], f[10:0], tdm, en};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_start(bit alt);
        @(negedge clk);
        while (!(alt ? fst_a : fst_d)) @(negedge clk);
    endtask

    // R5 R6 R7 R8 R9 R10: cycle-exact sweep over two frames
    task automatic sweep(bit tdm, int fraw, int braw);
        int b_eff, f_eff, per;
        int e_b, e_w, e_fa, e_fs;
        b_eff = (braw == 0) ? 1 : braw;
        f_eff = (fraw == 0) ? 1 : fraw;
        per   = b_eff * f_eff;
        e_b = 0; e_w = 0; e_fa = 0; e_fs = 0;
        ctrl_d = mk_def(1'b1, tdm, fraw, braw);
        wait_start(1'b0);
        for (int k = 0; k < 2 * per; k++) begin
            int m, bi;
            bit xb, xw, xfa, xfs;
            m   = k % b_eff;
            bi  = (k / b_eff) % f_eff;
            xb  = (m < (b_eff + 1) / 2);
            xfa = (b_eff == 1) ? 1'b1 : (m == (b_eff + 1) / 2);
            xfs = (k % per == 0);
            xw  = tdm ? (bi == 0) : (bi >= f_eff / 2);
            if (bclk_d  !== xb)  e_b++;
            if (bfall_d !== xfa) e_fa++;
            if (fst_d   !== xfs) e_fs++;
            if (fclk_d  !== xw)  e_w++;
            @(negedge clk);
        end
        check(e_b == 0,  (braw == 0) ? "R9 R5 bclk shape, zero B" : "R5 bclk shape", e_b, 0);
        check(e_fa == 0, "R10 fall strobe", e_fa, 0);
        check(e_fs == 0, (fraw == 0) ? "R9 R6 frame start, zero F" : "R6 frame start", e_fs, 0);
        check(e_w == 0,  tdm ? "R8 R2 tdm sync" : "R7 R2 word select", e_w, 0);
    endtask

    // R3 R4: period measurement for wide field values
    task automatic periods(bit alt, int exp_bit, int exp_hi, int exp_frame, string req);
        int n;
        wait_start(alt);
        n = 0;
        do begin @(negedge clk); n++; end while (!(alt ? fst_a : fst_d));
        check(n == exp_frame, {req, " frame period"}, n, exp_frame);
        n = 0;
        while (!(alt ? bclk_a : bclk_d)) @(negedge clk);
        while (alt ? bclk_a : bclk_d) begin @(negedge clk); n++; end
        check(n == exp_hi, {req, " bclk high run"}, n, exp_hi);
        n = 0;
        while (!(alt ? bfall_a : bfall_d)) @(negedge clk);
        do begin @(negedge clk); n++; end while (!(alt ? bfall_a : bfall_d));
        check(n == exp_bit, {req, " bit period"}, n, exp_bit);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({bclk_d, fclk_d, bfall_d, fst_d} == 4'b0, "R1 reset quiet",
              {bclk_d, fclk_d, bfall_d, fst_d}, 0);
        ctrl_d = mk_def(1'b0, 1'b1, 4, 3);
        repeat (5) @(negedge clk);
        check({bclk_d, fclk_d, bfall_d, fst_d} == 4'b0, "R1 disabled word ignored",
              {bclk_d, fclk_d, bfall_d, fst_d}, 0);

        // near-exhaustive sweep of small divisors, both framings
        for (int t = 0; t < 2; t++)
            foreach (sweep_b[i])
                foreach (sweep_f[j])
                    sweep(t[0], sweep_f[j], sweep_b[i]);

        // R11: mid-frame change waits for frame end
        ctrl_d = mk_def(1'b1, 1'b0, 4, 3);
        wait_start(1'b0);
        repeat (5) @(negedge clk);
        ctrl_d = mk_def(1'b1, 1'b0, 2, 5);
        n = 5;
        do begin @(negedge clk); n++; end while (!fst_d);
        check(n == 12, "R11 old frame completes", n, 12);
        repeat (3) @(negedge clk);
        ctrl_d = '0;
        repeat (2) @(negedge clk);
        check(bclk_d == 1'b1, "R11 disable deferred", bclk_d, 1);
        repeat (5) @(negedge clk);
        check({bclk_d, fclk_d, bfall_d, fst_d} == 4'b0, "R11 R1 stopped at frame end",
              {bclk_d, fclk_d, bfall_d, fst_d}, 0);
        repeat (10) @(negedge clk);
        check({bclk_d, fclk_d, bfall_d, fst_d} == 4'b0, "R1 stays quiet",
              {bclk_d, fclk_d, bfall_d, fst_d}, 0);

        // R12: enable from idle is immediate
        ctrl_d = mk_def(1'b1, 1'b1, 3, 2);
        @(negedge clk);
        check({fst_d, bclk_d, fclk_d} == 3'b111, "R12 immediate start",
              {fst_d, bclk_d, fclk_d}, 7);

        // R3: wide fields, default layout
        ctrl_d = mk_def(1'b1, 1'b0, 2, 4100);
        periods(1'b0, 4100, 2050, 8200, "R3 upper B bits");
        ctrl_d = mk_def(1'b1, 1'b0, 300, 2);
        periods(1'b0, 2, 1, 600, "R3 upper F bits");

        // R4: alternate layout
        ctrl_a = mk_alt(1'b1, 1'b0, 600, 3);
        @(negedge clk);
        check(fst_a == 1'b1, "R4 R12 alt immediate start", fst_a, 1);
        periods(1'b1, 3, 2, 1800, "R4 upper F bits");
        ctrl_a = mk_alt(1'b1, 1'b1, 2, 1030);
        periods(1'b1, 1030, 515, 2060, "R4 upper B bits");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    int sweep_b [7] = '{0, 1, 2, 3, 4, 5, 7};
    int sweep_f [6] = '{0, 1, 2, 3, 5, 8};
endmodule